// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps per-source state for a parameterised set of interrupt inputs and hands interrupts to a downstream presenter. Each input is either level-sensitive or message-style; this is fixed by a parameter mask. For every source the block keeps a target server number, a current priority, a saved priority and four status flags. When a source becomes deliverable, the block offers it to the presenter as a source number, a priority and a server over a valid/ready handshake.

The presenter reports back on three strobes. A reject hands an offered source back. An end-of-interrupt (EOI) retires a level source. A resend request makes the block walk all sources and re-offer any source that is still owed. A configuration port writes or reads a source's server and priority, and it can disable or enable a source. Source numbers on both ports start at a fixed base.

A three-state controller serialises all work. The states are ST_IDLE, ST_SCAN and ST_OFFER.
- ST_IDLE handles one item per cycle, in this order: a configuration command, then the start of a pending resend scan, then the lowest-numbered source event.
  - A deliverable result moves it to ST_OFFER.
  - A pending resend moves it to ST_SCAN.
- ST_SCAN visits one source per cycle in ascending order.
  - It goes to ST_OFFER when a source must be offered.
  - After the last source it returns to ST_IDLE.
- ST_OFFER holds the offer until ready is seen. It then returns to ST_SCAN if the scan is unfinished, and to ST_IDLE otherwise.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, every source has all flags clear and both priorities at 0xFF. A read of any source returns server 0 and priority 0xFF, and no offer is valid.
- R2: Priority 0xFF masks a source and is never offered. A message event on a masked source is remembered in the masked-pending flag (flag bit 3). A later write or enable that unmasks the source offers it once and clears the flag.
- R3: A rising edge on a message source's line, while the source is unmasked, offers source number base+index with that source's priority and server.
- R4: A level source's asserted flag (bit 0) follows its line. If the source is unmasked, asserted and not already sent (bit 1), it is offered once and marked sent. It is not offered again while it stays sent.
- R5: A reject sets the source's rejected flag (bit 2) and clears its sent flag. A resend scan re-offers a rejected, unmasked message source once and clears its rejected flag. The same scan re-offers a level source that is unmasked, asserted and not sent.
- R6: An EOI clears the sent flag of a level source. An EOI has no effect on a message source.
- R7: cfg_cmd 0 (write) stores the server, and stores the priority into both the priority and the saved priority. cfg_cmd 1 (read) returns the stored server and priority.
- R8: cfg_cmd 2 (disable) copies the priority into the saved priority and sets the priority to 0xFF. cfg_cmd 3 (enable) copies the saved priority back into the priority, and then offers the source if it is now deliverable.
- R9: A command whose source number lies outside base..base+NUM_SRC-1 gets cfg_err=1 and changes nothing. So does a write whose server is NUM_SERVERS or more.
- R10: An offer holds its source, priority and server steady while valid is high and ready is low. It completes on the first edge at which ready is high.
- R11: In idle, a configuration command is served first, then a pending resend, then events. Simultaneous events are served lowest index first, and the scan runs in ascending order. Triggers that arrive during a scan are held and served after it ends.
- R12: cfg_ack is a single-cycle pulse, one edge after an idle block accepts cfg_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NUM_SRC | Interrupt lines; level for LEVEL_MASK bits, rising edge triggers otherwise |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Presenter takes the offer |
| offer_src | output | SRC_NUM_W | Offered source number (base + index) |
| offer_prio | output | 8 | Offered priority |
| offer_server | output | SRV_W | Target server of the offer |
| pres_reject | input | 1 | Reject strobe for pres_src |
| pres_eoi | input | 1 | EOI strobe for pres_src |
| pres_src | input | SRC_NUM_W | Source number for reject/EOI |
| pres_resend | input | 1 | Resend request strobe |
| cfg_req | input | 1 | Configuration command request, held until cfg_ack |
| cfg_cmd | input | 2 | 0 write, 1 read, 2 disable, 3 enable |
| cfg_src | input | SRC_NUM_W | Source number of the command |
| cfg_server | input | SRV_W | Server for a write |
| cfg_prio | input | 8 | Priority for a write |
| cfg_ack | output | 1 | Command done pulse |
| cfg_err | output | 1 | Status of the last command, 1 = rejected |
| cfg_rd_server | output | SRV_W | Server returned by a read |
| cfg_rd_prio | output | 8 | Priority returned by a read |

## Verification
A level change reaches offer_valid one edge after the line moves. A message pulse needs two edges, because it is first edge-detected into a held request. A command is acknowledged one edge after acceptance, and an offer it causes appears on that same edge. The bench drives every input three nanoseconds after a rising edge and samples on the falling edge. A behavioural model queues the expected offers. Each completed handshake is compared, on the clock where it happens, with the head of that queue. Each command checks that the acknowledge arrives on exactly the second falling edge after the request. Every stimulus is followed by a quiet window, after which the queue must be empty.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    // bit 3 masked-pending, bit 2 rejected, bit 1 sent, bit 0 asserted
    typedef struct packed {
        logic mpend;
        logic rejected;
        logic sent;
        logic asserted;
    } src_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_OFFER = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        CMD_WRITE   = 2'd0,
        CMD_READ    = 2'd1,
        CMD_DISABLE = 2'd2,
        CMD_ENABLE  = 2'd3
    } cfg_cmd_t;
endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_src_entry.sv
module irq_src_entry
    import irq_src_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [SRV_W-1:0]  upd_server,
    input  logic [PRIO_W-1:0] upd_prio,
    input  logic [PRIO_W-1:0] upd_saved,
    input  src_flags_t        upd_flags,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] saved,
    output src_flags_t        flags
);
    logic [SRV_W-1:0]  server_d;
    logic [PRIO_W-1:0] prio_d, saved_d;
    src_flags_t        flags_d;

    // controller update first, presenter strobes applied on top
    always_comb begin
        server_d = server;
        prio_d   = prio;
        saved_d  = saved;
        flags_d  = flags;
        if (upd_en) begin
            server_d = upd_server;
            prio_d   = upd_prio;
            saved_d  = upd_saved;
            flags_d  = upd_flags;
        end
        if (rej_hit) begin
            flags_d.rejected = 1'b1;
            flags_d.sent     = 1'b0;
        end
        if (eoi_hit && IS_LEVEL) flags_d.sent = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            server <= '0;
            prio   <= PRIO_MASKED;
            saved  <= PRIO_MASKED;
            flags  <= '0;
        end else begin
            server <= server_d;
            prio   <= prio_d;
            saved  <= saved_d;
            flags  <= flags_d;
        end
    end

    assert_reject_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rej_hit |=> (flags.rejected && !flags.sent));

    assert_eoi_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_LEVEL && eoi_hit) |=> !flags.sent);

    assert_eoi_msg_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_LEVEL && eoi_hit && !rej_hit && !upd_en) |=> $stable(flags));
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irq_src_pkg::*;
#(
    parameter int                 NUM_SRC     = 8,
    parameter int                 SRC_BASE    = 16,
    parameter int                 SRC_NUM_W   = 8,
    parameter int                 NUM_SERVERS = 4,
    parameter int                 SRV_W       = 4,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK  = 8'h0F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_line,
    output logic                 offer_valid,
    input  logic                 offer_ready,
    output logic [SRC_NUM_W-1:0] offer_src,
    output logic [7:0]           offer_prio,
    output logic [SRV_W-1:0]     offer_server,
    input  logic                 pres_reject,
    input  logic                 pres_eoi,
    input  logic [SRC_NUM_W-1:0] pres_src,
    input  logic                 pres_resend,
    input  logic                 cfg_req,
    input  logic [1:0]           cfg_cmd,
    input  logic [SRC_NUM_W-1:0] cfg_src,
    input  logic [SRV_W-1:0]     cfg_server,
    input  logic [7:0]           cfg_prio,
    output logic                 cfg_ack,
    output logic                 cfg_err,
    output logic [SRV_W-1:0]     cfg_rd_server,
    output logic [7:0]           cfg_rd_prio
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [SRC_NUM_W-1:0] BASE_V = SRC_NUM_W'(SRC_BASE);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    function automatic logic num_ok(input logic [SRC_NUM_W-1:0] n);
        return (int'(n) >= SRC_BASE) && (int'(n) < SRC_BASE + NUM_SRC);
    endfunction

    function automatic logic [IDX_W-1:0] num_idx(input logic [SRC_NUM_W-1:0] n);
        logic [SRC_NUM_W-1:0] d;
        d = n - BASE_V;
        return d[IDX_W-1:0];
    endfunction

    // registered state
    ctl_state_t           state_q, state_d;
    logic [IDX_W-1:0]     scan_q, scan_d;
    logic                 ret_q, ret_d;
    logic                 resend_q, resend_d;
    logic [NUM_SRC-1:0]   hold_q, hold_d, hold_clr;
    logic [NUM_SRC-1:0]   line_q;
    logic                 ov_q, ov_d;
    logic [SRC_NUM_W-1:0] os_q, os_d;
    logic [PRIO_W-1:0]    op_q, op_d;
    logic [SRV_W-1:0]     osv_q, osv_d;
    logic                 ack_q, ack_d;
    logic                 err_q, err_d;
    logic [SRV_W-1:0]     rds_q, rds_d;
    logic [PRIO_W-1:0]    rdp_q, rdp_d;

    // per-source storage
    logic [SRV_W-1:0]  e_srv   [NUM_SRC];
    logic [PRIO_W-1:0] e_prio  [NUM_SRC];
    logic [PRIO_W-1:0] e_saved [NUM_SRC];
    src_flags_t        e_flags [NUM_SRC];

    // working copy of the selected source
    logic [IDX_W-1:0]  sel;
    logic              do_upd, chk_lvl, chk_mp, give, is_lvl;
    logic [SRV_W-1:0]  w_srv;
    logic [PRIO_W-1:0] w_prio, w_saved;
    src_flags_t        w_flags;

    logic [NUM_SRC-1:0] msg_trig, ev_req;
    logic               ev_any;
    logic [IDX_W-1:0]   ev_idx;
    logic               cfg_take;

    assign msg_trig = src_line & ~line_q & ~LEVEL_MASK;
    assign cfg_take = cfg_req && !ack_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            assign ev_req[gi] = LEVEL_MASK[gi] ? (src_line[gi] ^ e_flags[gi].asserted)
                                               : hold_q[gi];
            irq_src_entry #(
                .SRV_W    (SRV_W),
                .IS_LEVEL (LEVEL_MASK[gi])
            ) u_entry (
                .clk        (clk),
                .rst_n      (rst_n),
                .upd_en     (do_upd && (sel == IDX_W'(gi))),
                .upd_server (w_srv),
                .upd_prio   (w_prio),
                .upd_saved  (w_saved),
                .upd_flags  (w_flags),
                .rej_hit    (pres_reject && num_ok(pres_src) && (num_idx(pres_src) == IDX_W'(gi))),
                .eoi_hit    (pres_eoi && num_ok(pres_src) && (num_idx(pres_src) == IDX_W'(gi))),
                .server     (e_srv[gi]),
                .prio       (e_prio[gi]),
                .saved      (e_saved[gi]),
                .flags      (e_flags[gi])
            );
        end
    endgenerate

    irq_src_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req (ev_req),
        .any (ev_any),
        .idx (ev_idx)
    );

    // next-state and per-source work
    always_comb begin
        state_d  = state_q;
        scan_d   = scan_q;
        ret_d    = ret_q;
        resend_d = resend_q | pres_resend;
        hold_clr = '0;
        ov_d  = ov_q;
        os_d  = os_q;
        op_d  = op_q;
        osv_d = osv_q;
        ack_d = 1'b0;
        err_d = err_q;
        rds_d = rds_q;
        rdp_d = rdp_q;
        do_upd  = 1'b0;
        chk_lvl = 1'b0;
        chk_mp  = 1'b0;
        give    = 1'b0;

        unique case (state_q)
            ST_IDLE: sel = cfg_take ? num_idx(cfg_src) : ev_idx;
            ST_SCAN: sel = scan_q;
            default: sel = '0;
        endcase

        w_srv   = e_srv[sel];
        w_prio  = e_prio[sel];
        w_saved = e_saved[sel];
        w_flags = e_flags[sel];
        is_lvl  = LEVEL_MASK[sel];

        unique case (state_q)
            ST_IDLE: begin
                ret_d = 1'b0;
                if (cfg_take) begin
                    ack_d = 1'b1;
                    err_d = !num_ok(cfg_src) ||
                            ((cfg_cmd == CMD_WRITE) && (int'(cfg_server) >= NUM_SERVERS));
                    if (!err_d) begin
                        unique case (cfg_cmd)
                            CMD_WRITE: begin
                                w_srv   = cfg_server;
                                w_prio  = cfg_prio;
                                w_saved = cfg_prio;
                            end
                            CMD_READ: begin
                                rds_d = w_srv;
                                rdp_d = w_prio;
                            end
                            CMD_DISABLE: begin
                                w_saved = w_prio;
                                w_prio  = PRIO_MASKED;
                            end
                            default: begin
                                w_prio = w_saved;
                            end
                        endcase
                        if (cfg_cmd != CMD_READ) begin
                            do_upd  = 1'b1;
                            chk_lvl = is_lvl;
                            chk_mp  = !is_lvl;
                        end
                    end
                end else if (resend_q) begin
                    state_d  = ST_SCAN;
                    scan_d   = '0;
                    resend_d = pres_resend;
                end else if (ev_any) begin
                    do_upd = 1'b1;
                    if (is_lvl) begin
                        w_flags.asserted = src_line[sel];
                        chk_lvl = 1'b1;
                    end else begin
                        hold_clr[sel] = 1'b1;
                        if (w_prio == PRIO_MASKED) w_flags.mpend = 1'b1;
                        else                       give = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                do_upd = 1'b1;
                if (is_lvl) begin
                    chk_lvl = 1'b1;
                end else if (w_flags.rejected) begin
                    w_flags.rejected = 1'b0;
                    give = (w_prio != PRIO_MASKED);
                end
                ret_d   = (scan_q != LAST_IDX);
                state_d = (scan_q == LAST_IDX) ? ST_IDLE : ST_SCAN;
                scan_d  = (scan_q == LAST_IDX) ? scan_q : scan_q + IDX_W'(1);
            end
            ST_OFFER: begin
                if (offer_ready) begin
                    ov_d    = 1'b0;
                    state_d = ret_q ? ST_SCAN : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (chk_lvl && (w_prio != PRIO_MASKED) && w_flags.asserted && !w_flags.sent) begin
            w_flags.sent = 1'b1;
            give = 1'b1;
        end
        if (chk_mp && w_flags.mpend && (w_prio != PRIO_MASKED)) begin
            w_flags.mpend = 1'b0;
            give = 1'b1;
        end
        if (give) begin
            ov_d    = 1'b1;
            os_d    = BASE_V + SRC_NUM_W'(sel);
            op_d    = w_prio;
            osv_d   = w_srv;
            state_d = ST_OFFER;
        end
        hold_d = (hold_q & ~hold_clr) | msg_trig;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            scan_q   <= '0;
            ret_q    <= 1'b0;
            resend_q <= 1'b0;
            hold_q   <= '0;
            line_q   <= '0;
            ov_q     <= 1'b0;
            os_q     <= '0;
            op_q     <= PRIO_MASKED;
            osv_q    <= '0;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            rds_q    <= '0;
            rdp_q    <= PRIO_MASKED;
        end else begin
            state_q  <= state_d;
            scan_q   <= scan_d;
            ret_q    <= ret_d;
            resend_q <= resend_d;
            hold_q   <= hold_d;
            line_q   <= src_line;
            ov_q     <= ov_d;
            os_q     <= os_d;
            op_q     <= op_d;
            osv_q    <= osv_d;
            ack_q    <= ack_d;
            err_q    <= err_d;
            rds_q    <= rds_d;
            rdp_q    <= rdp_d;
        end
    end

    // outputs
    always_comb begin
        offer_valid   = ov_q;
        offer_src     = os_q;
        offer_prio    = op_q;
        offer_server  = osv_q;
        cfg_ack       = ack_q;
        cfg_err       = err_q;
        cfg_rd_server = rds_q;
        cfg_rd_prio   = rdp_q;
    end

    assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !offer_ready) |=>
            (offer_valid && $stable(offer_src) && $stable(offer_prio) && $stable(offer_server)));

    assert_no_masked_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_prio != PRIO_MASKED));

    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);

    assert_offer_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> num_ok(offer_src));
endmodule

// File: tb/irq_source_ctrl_test.sv
module irq_source_ctrl_test;
    localparam int N    = 8;
    localparam int BASE = 16;
    localparam logic [N-1:0] LVL = 8'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_line = '0;
    logic offer_valid, offer_ready = 1'b1;
    logic [7:0] offer_src, offer_prio;
    logic [3:0] offer_server;
    logic pres_reject = 1'b0, pres_eoi = 1'b0, pres_resend = 1'b0;
    logic [7:0] pres_src = '0;
    logic cfg_req = 1'b0;
    logic [1:0] cfg_cmd = '0;
    logic [7:0] cfg_src = '0;
    logic [3:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0;
    logic cfg_ack, cfg_err;
    logic [3:0] cfg_rd_server;
    logic [7:0] cfg_rd_prio;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    irq_source_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_line(src_line),
        .offer_valid(offer_valid), .offer_ready(offer_ready),
        .offer_src(offer_src), .offer_prio(offer_prio), .offer_server(offer_server),
        .pres_reject(pres_reject), .pres_eoi(pres_eoi), .pres_src(pres_src),
        .pres_resend(pres_resend), .cfg_req(cfg_req), .cfg_cmd(cfg_cmd),
        .cfg_src(cfg_src), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err),
        .cfg_rd_server(cfg_rd_server), .cfg_rd_prio(cfg_rd_prio)
    );

    // behavioural reference model
    int m_srv[N], m_prio[N], m_saved[N];
    bit m_asr[N], m_sent[N], m_rej[N], m_mp[N];
    int q_src[$], q_prio[$], q_srv[$];

    function automatic void push(int i);
        q_src.push_back(BASE + i);
        q_prio.push_back(m_prio[i]);
        q_srv.push_back(m_srv[i]);
    endfunction
    function automatic void m_lvl(int i);
        if (m_prio[i] != 255 && m_asr[i] && !m_sent[i]) begin
            m_sent[i] = 1;
            push(i);
        end
    endfunction
    function automatic void m_after(int i);
        if (LVL[i]) m_lvl(i);
        else if (m_mp[i] && m_prio[i] != 255) begin
            m_mp[i] = 0;
            push(i);
        end
    endfunction
    function automatic void m_resend();
        for (int i = 0; i < N; i++) begin
            if (LVL[i]) m_lvl(i);
            else if (m_rej[i]) begin
                m_rej[i] = 0;
                if (m_prio[i] != 255) push(i);
            end
        end
    endfunction

    task automatic fail_line(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    // per-clock comparison of offers against the model
    logic pv = 1'b0;
    logic [7:0] ps, pp;
    logic [3:0] psv;
    always @(negedge clk) begin
        if (rst_n && offer_valid) begin
            if (!offer_ready && pv) begin
                checks++;
                if (offer_src != ps || offer_prio != pp || offer_server != psv)
                    fail_line("R10", "offer changed while stalled", offer_src, ps);
            end
            if (offer_ready) begin
                if (q_src.size() == 0) begin
                    checks++;
                    fail_line("R3", "unexpected offer src", offer_src, -1);
                end else begin
                    chk("R11", "offer src", offer_src, q_src.pop_front());
                    chk("R3", "offer prio", offer_prio, q_prio.pop_front());
                    chk("R3", "offer server", offer_server, q_srv.pop_front());
                end
            end
        end
        pv  <= offer_valid && !offer_ready;
        ps  <= offer_src;
        pp  <= offer_prio;
        psv <= offer_server;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic settle(string req);
        repeat (12) step();
        chk(req, "pending expected offers", q_src.size(), 0);
    endtask

    task automatic cfg(int cmd, int src, int srv, int prio, int exp_err,
                       int exp_srv, int exp_prio, string req);
        int waited;
        int idx;
        idx = src - BASE;
        if (exp_err == 0) begin
            if (cmd == 0) begin
                m_srv[idx] = srv; m_prio[idx] = prio; m_saved[idx] = prio; m_after(idx);
            end else if (cmd == 2) begin
                m_saved[idx] = m_prio[idx]; m_prio[idx] = 255; m_after(idx);
            end else if (cmd == 3) begin
                m_prio[idx] = m_saved[idx]; m_after(idx);
            end
        end
        step();
        cfg_req = 1'b1; cfg_cmd = 2'(cmd); cfg_src = 8'(src);
        cfg_server = 4'(srv); cfg_prio = 8'(prio);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cfg_ack && waited < 10);
        chk("R12", "ack latency", waited, 2);
        chk(req, "cfg_err", cfg_err, exp_err);
        if (cmd == 1 && exp_err == 0) begin
            chk(req, "read server", cfg_rd_server, exp_srv);
            chk(req, "read prio", cfg_rd_prio, exp_prio);
        end
        step();
        cfg_req = 1'b0;
        settle(req);
    endtask

    task automatic pulse_msg(logic [N-1:0] m);
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (m_prio[i] == 255) m_mp[i] = 1;
                else push(i);
            end
        end
        step();
        src_line = src_line | m;
        step();
        src_line = src_line & ~m;
    endtask

    task automatic set_level(int i, bit v);
        m_asr[i] = v;
        m_lvl(i);
        step();
        src_line[i] = v;
    endtask

    task automatic strobe_reject(int src);
        m_rej[src - BASE] = 1; m_sent[src - BASE] = 0;
        step(); pres_reject = 1'b1; pres_src = 8'(src);
        step(); pres_reject = 1'b0;
    endtask

    task automatic strobe_eoi(int src);
        if (LVL[src - BASE]) m_sent[src - BASE] = 0;
        step(); pres_eoi = 1'b1; pres_src = 8'(src);
        step(); pres_eoi = 1'b0;
    endtask

    task automatic strobe_resend();
        m_resend();
        step(); pres_resend = 1'b1;
        step(); pres_resend = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_srv[i] = 0; m_prio[i] = 255; m_saved[i] = 255;
            m_asr[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "offer_valid after reset", offer_valid, 0);
        chk("R1", "cfg_ack after reset", cfg_ack, 0);
        cfg(1, 16, 0, 0, 0, 0, 255, "R1");
        cfg(1, 23, 0, 0, 0, 0, 255, "R1");

        // R7 configuration writes and reads
        cfg(0, 16, 1, 5, 0, 0, 0, "R7");
        cfg(0, 20, 2, 3, 0, 0, 0, "R7");
        cfg(0, 21, 3, 255, 0, 0, 0, "R7");
        cfg(0, 17, 0, 7, 0, 0, 0, "R7");
        cfg(1, 20, 0, 0, 0, 2, 3, "R7");

        // R9 errors change nothing
        cfg(0, 40, 1, 1, 1, 0, 0, "R9");
        cfg(2, 15, 0, 0, 1, 0, 0, "R9");
        cfg(0, 17, 4, 1, 1, 0, 0, "R9");
        cfg(1, 17, 0, 0, 0, 0, 7, "R9");

        // R3 message offer
        pulse_msg(8'h10);
        settle("R3");

        // R2 masked message remembered, offered on unmask
        pulse_msg(8'h20);
        settle("R2");
        cfg(0, 21, 3, 2, 0, 0, 0, "R2");

        // R4 level offer, once
        set_level(0, 1'b1);
        settle("R4");
        // R6 EOI on level clears sent; no re-offer without resend
        strobe_eoi(16);
        settle("R6");
        strobe_resend();
        settle("R4");
        // R5 reject then resend re-offers asserted level source
        strobe_reject(16);
        strobe_resend();
        settle("R5");
        set_level(0, 1'b0);
        settle("R4");

        // R5/R6 message reject, EOI no effect, resend once
        pulse_msg(8'h10);
        settle("R3");
        strobe_reject(20);
        strobe_eoi(20);
        settle("R6");
        strobe_resend();
        settle("R5");
        strobe_resend();
        settle("R5");

        // R8 disable and enable
        cfg(2, 17, 0, 0, 0, 0, 0, "R8");
        cfg(1, 17, 0, 0, 0, 0, 255, "R8");
        set_level(1, 1'b1);
        settle("R8");
        cfg(3, 17, 0, 0, 0, 0, 0, "R8");
        cfg(1, 17, 0, 0, 0, 0, 7, "R8");

        // R10 stalled offer
        step(); offer_ready = 1'b0;
        pulse_msg(8'h10);
        repeat (6) step();
        chk("R10", "offer held valid", offer_valid, 1);
        chk("R10", "held src", offer_src, 20);
        offer_ready = 1'b1;
        settle("R10");

        // R11 ordering: simultaneous events, triggers during a scan
        cfg(0, 22, 1, 9, 0, 0, 0, "R11");
        cfg(0, 23, 0, 1, 0, 0, 0, "R11");
        pulse_msg(8'h50);
        settle("R11");
        strobe_reject(20);
        strobe_reject(22);
        m_resend();
        step(); pres_resend = 1'b1;
        step(); pres_resend = 1'b0;
        pulse_msg(8'h80);
        settle("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule